// File: doc/BRIEF.md
# System Tick Down-Counter Timer

This block is a periodic down-counter of 24 bits, the heartbeat timer of a processor subsystem. Software sets a reload value, picks whether the counter steps on every core clock cycle or only on cycles where an external reference tick strobe is high, and enables it. Each time the count steps from 1 to 0 the block sets a sticky wrap flag. If the exception enable is set, it also sends a one-cycle tick request to the interrupt controller. On the next count after reaching zero the counter loads the reload value again, so it runs without stopping until it is disabled.

Software reaches the block through a simple synchronous register port. The port has a write strobe, a read strobe, a byte address and 32-bit data in each direction. Read data is combinational from the selected register. The read strobe lets a read of the status word clear the wrap flag as a side effect. A write of any value to the current value word zeroes the counter and drops the flag without raising a request, so software can restart a period cleanly.

Top module: `tick_timer`

## Requirements
- R1: After reset, the words at byte offsets 0x10 (control/status), 0x14 (reload) and 0x18 (current value) all read 0, and the tick request is low.
- R2: Status bit 0 enables counting. While it is 0, the current value holds whatever clock source and ticks are present.
- R3: Status bit 2 selects the clock source. With 1, the counter steps on every clock cycle. With 0, it steps only on cycles where `refTick` is high and holds on all other cycles.
- R4: On each step, a nonzero count decrements by one and a zero count loads the reload value. The reload and current value fields occupy bits 23:0, bits 31:24 read as 0, and written upper bits are dropped.
- R5: A write of any value to offset 0x18 sets the count to 0 and clears the wrap flag, and it raises no tick request even with the exception enabled.
- R6: With status bit 1 set, each 1-to-0 step gives `tickIrq` high for exactly one cycle, namely the cycle in which the current value first reads 0.
- R7: With status bit 1 clear, `tickIrq` stays low, and the 1-to-0 step still sets the wrap flag.
- R8: The wrap flag is status bit 16. It is set by a 1-to-0 step. A read of offset 0x10 returns the flag and clears it, so the next read shows 0. A step on the same cycle as the read wins.
- R9: With reload 0, the counter stays at 0 while enabled and raises neither the flag nor a tick request.
- R10: Status bits other than 0, 1, 2 and 16 read as 0, and writes to them have no effect. Writing status bit 16 does not set the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regRe | input | 1 | Register read strobe (drives clear-on-read) |
| regAddr | input | 8 | Byte offset of the register accessed |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data of the addressed register |
| refTick | input | 1 | One-cycle external reference tick strobe, already synchronous |
| tickIrq | output | 1 | One-cycle tick exception request |

## Verification
The hardest case to reach is a known count at a known cycle, because in core-clock mode the counter moves on every edge while the register port itself takes cycles. Most of the stimulus therefore runs in reference-tick mode, where the bench controls each step through `refTick`. This puts the counter exactly at 1, at 0, or mid-period before a flag read, a software clear or an exception-enable change. Core-clock mode is then checked once with a cycle-counted enable window whose final count is computed from the number of edges.

// File: rtl/tick_pkg.sv
package tick_pkg;
  localparam int ADDR_W   = 8;
  localparam int DATA_W   = 32;
  localparam int FLAG_BIT = 16;

  localparam logic [ADDR_W-1:0] OFS_STAT   = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_RELOAD = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_CUR    = 8'h18;

  // Strobes from control to datapath
  typedef struct packed {
    logic step;     // count one step this cycle
    logic swClear;  // software write to current value
  } cntCmd_t;
endpackage

// File: rtl/tick_dp.sv
module tick_dp
  import tick_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntCmd_t          cmd,
  input  logic [CNT_W-1:0] reloadVal,
  output logic [CNT_W-1:0] cntVal,
  output logic             hitZero
);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] ZERO = '0;

  logic [CNT_W-1:0] cntQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ <= ZERO;
    end else if (cmd.swClear) begin
      cntQ <= ZERO;
    end else if (cmd.step) begin
      if (cntQ == ZERO) cntQ <= reloadVal;
      else              cntQ <= cntQ - ONE;
    end
  end

  assign cntVal  = cntQ;
  assign hitZero = cmd.step && !cmd.swClear && (cntQ == ONE);

  AST_SWCLR_ZEROES: assert property (@(posedge clk) disable iff (!rstN)
    cmd.swClear |=> (cntQ == ZERO)); // R5
  AST_HOLD_NO_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.step && !cmd.swClear) |=> $stable(cntQ)); // R2
  AST_DECR_BY_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.step && !cmd.swClear && cntQ != ZERO) |=> (cntQ == $past(cntQ) - ONE)); // R4
  AST_RELOAD_ZERO_STAYS: assert property (@(posedge clk) disable iff (!rstN)
    (cntQ == ZERO && reloadVal == ZERO && !cmd.swClear) |=> (cntQ == ZERO)); // R9
endmodule

// File: rtl/tick_ctrl.sv
module tick_ctrl
  import tick_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic              regRe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              refTick,
  input  logic [CNT_W-1:0]  cntVal,
  input  logic              hitZero,
  output cntCmd_t           cmd,
  output logic [CNT_W-1:0]  reloadVal,
  output logic              tickIrq
);
  localparam int PAD_W = DATA_W - CNT_W;

  logic enQ, irqEnQ, coreClkQ, flagQ, tickIrqQ;
  logic [CNT_W-1:0] reloadQ;
  logic wrStat, wrReload, wrCur, rdStat;
  wire  unusedWdata = ^regWdata[DATA_W-1:CNT_W];

  assign wrStat   = regWe && (regAddr == OFS_STAT);
  assign wrReload = regWe && (regAddr == OFS_RELOAD);
  assign wrCur    = regWe && (regAddr == OFS_CUR);
  assign rdStat   = regRe && (regAddr == OFS_STAT);

  assign cmd.step    = enQ && (coreClkQ || refTick);
  assign cmd.swClear = wrCur;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enQ      <= 1'b0;
      irqEnQ   <= 1'b0;
      coreClkQ <= 1'b0;
      flagQ    <= 1'b0;
      tickIrqQ <= 1'b0;
      reloadQ  <= '0;
    end else begin
      if (wrStat) begin
        enQ      <= regWdata[0];
        irqEnQ   <= regWdata[1];
        coreClkQ <= regWdata[2];
      end
      if (wrReload) reloadQ <= regWdata[CNT_W-1:0];
      if (hitZero)              flagQ <= 1'b1;
      else if (wrCur || rdStat) flagQ <= 1'b0;
      tickIrqQ <= hitZero && irqEnQ;
    end
  end

  always_comb begin
    regRdata = '0;
    unique case (regAddr)
      OFS_STAT: begin
        regRdata[0]        = enQ;
        regRdata[1]        = irqEnQ;
        regRdata[2]        = coreClkQ;
        regRdata[FLAG_BIT] = flagQ;
      end
      OFS_RELOAD: regRdata = {{PAD_W{1'b0}}, reloadQ};
      OFS_CUR:    regRdata = {{PAD_W{1'b0}}, cntVal};
      default:    regRdata = '0;
    endcase
  end

  assign reloadVal = reloadQ;
  assign tickIrq   = tickIrqQ;

  AST_IRQ_HAS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    tickIrq |-> flagQ); // R6
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    tickIrq |=> !tickIrq); // R6
  AST_IRQ_AT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    tickIrq |-> (cntVal == '0)); // R6
  AST_NO_IRQ_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    !irqEnQ |=> !tickIrq); // R7
  AST_FLAG_CLR_ON_READ: assert property (@(posedge clk) disable iff (!rstN)
    (rdStat && !hitZero) |=> !flagQ); // R8
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic              regRe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              refTick,
  output logic              tickIrq
);
  cntCmd_t          cmd;
  logic [CNT_W-1:0] reloadVal;
  logic [CNT_W-1:0] cntVal;
  logic             hitZero;

  tick_ctrl #(.CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .regWe(regWe), .regRe(regRe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata),
    .refTick(refTick), .cntVal(cntVal), .hitZero(hitZero),
    .cmd(cmd), .reloadVal(reloadVal), .tickIrq(tickIrq)
  );

  tick_dp #(.CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .cmd(cmd),
    .reloadVal(reloadVal), .cntVal(cntVal), .hitZero(hitZero)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |=> !tickIrq); // R1
endmodule

// File: tb/tick_timer_tb.sv
module tick_timer_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0, regRe = 1'b0, refTick = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        tickIrq;

  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t sbQ[$];
  int total = 0, bad = 0, irqCnt = 0, irqMark = 0;

  always #10 clk = ~clk;

  tick_timer dut_i (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regRe(regRe),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .refTick(refTick), .tickIrq(tickIrq)
  );

  // Monitor: compares read data against the scoreboard queue
  always @(negedge clk) begin
    if (tickIrq) irqCnt++;
    if (regRe) begin
      item_t it;
      total++;
      if (sbQ.size() == 0) begin
        bad++;
        $display("FAIL %s unexpected read actual=%h expected=none", "R1", regRdata);
      end else begin
        it = sbQ.pop_front();
        if (regRdata !== it.exp) begin
          bad++;
          $display("FAIL %s actual=%h expected=%h", it.tag, regRdata, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1 regWe = 1'b1; regAddr = a; regWdata = d;
    @(posedge clk); #1 regWe = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(posedge clk); #1 regRe = 1'b1; regAddr = a;
    it.exp = e; it.tag = tag; sbQ.push_back(it);
    @(posedge clk); #1 regRe = 1'b0;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1 refTick = 1'b1;
      @(posedge clk); #1 refTick = 1'b0;
    end
  endtask

  task automatic chkIrq(input int expDelta, input string tag);
    total++;
    if (irqCnt - irqMark != expDelta) begin
      bad++;
      $display("FAIL %s irq pulses actual=%0d expected=%0d", tag, irqCnt - irqMark, expDelta);
    end
    irqMark = irqCnt;
  endtask

  initial begin
    #(20 * 100000);
    bad++;
    $display("FAIL watchdog R1..all actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R1 reset values
    rd(8'h10, 32'h0, "R1 status");
    rd(8'h14, 32'h0, "R1 reload");
    rd(8'h18, 32'h0, "R1 current");
    chkIrq(0, "R1");
    // R4 upper bits dropped
    wr(8'h14, 32'hFF00_0003);
    rd(8'h14, 32'h0000_0003, "R4 reload width");
    // reference mode, irq enabled
    wr(8'h10, 32'h3);
    tick(1);
    rd(8'h18, 32'd3, "R4 load on zero");
    tick(2);
    repeat (20) @(posedge clk);
    rd(8'h18, 32'd1, "R3 holds without refTick");
    chkIrq(0, "R6 none before zero");
    tick(1);
    rd(8'h10, 32'h0001_0003, "R8 flag set");
    rd(8'h10, 32'h0000_0003, "R8 flag cleared by read");
    chkIrq(1, "R6 one pulse");
    tick(1);
    rd(8'h18, 32'd3, "R4 reload after zero");
    // R2 disabled hold
    wr(8'h10, 32'h2);
    tick(3);
    rd(8'h18, 32'd3, "R2 disabled holds");
    // R7 no irq, flag still set
    wr(8'h10, 32'h1);
    tick(3);
    rd(8'h10, 32'h0001_0001, "R7 flag without irq");
    tick(4);
    tick(1);
    chkIrq(0, "R7 no irq");
    // R5 software clear with irq enabled
    wr(8'h10, 32'h3);
    wr(8'h18, 32'h0000_0ABC);
    rd(8'h18, 32'd0, "R5 current zeroed");
    rd(8'h10, 32'h0000_0003, "R5 flag cleared");
    chkIrq(0, "R5 no irq on clear");
    // R10 undefined bits
    wr(8'h10, 32'hFFFF_FFF8);
    rd(8'h10, 32'h0, "R10 undefined bits ignored");
    // R3 core clock mode
    wr(8'h14, 32'd1000);
    wr(8'h10, 32'h5);
    repeat (10) @(posedge clk);
    wr(8'h10, 32'h4);
    rd(8'h18, 32'd989, "R3 core clock steps every cycle");
    // R9 reload zero
    wr(8'h14, 32'h0);
    wr(8'h18, 32'h0);
    wr(8'h10, 32'h3);
    tick(5);
    rd(8'h18, 32'd0, "R9 stays zero");
    rd(8'h10, 32'h0000_0003, "R9 no flag");
    chkIrq(0, "R9 no irq");
    repeat (2) @(posedge clk);
    total++;
    if (sbQ.size() != 0) begin
      bad++;
      $display("FAIL R1 scoreboard leftover actual=%0d expected=0", sbQ.size());
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule